// File: doc/BRIEF.md
# Selectable-Source Reference Tick Divider

This block turns one of three phase-locked-loop tick streams into two divided reference tick strobes. Each of the three loops (named IO, ARM and DDR after the clock domains they feed) has its own 32-bit control word. Depending on that word, a loop passes its own multiplied tick stream on, is bypassed so that the raw input reference tick comes through instead, or is stopped. The multiplication itself is not modelled: each running loop's output ticks arrive on an input pin.

A 32-bit clock control word picks one of the loop outputs and a 6-bit divisor. The two outputs share that source and divisor. Each output has its own enable bit. Every output pulse lasts one clock cycle and comes once per N selected-source ticks. The block works in a single clock domain, and every tick stream is a one-cycle strobe in that domain.

Top module: `refclk_divider`

## Requirements
- R1: Bit 4 of a loop control word forces bypass: that loop's output equals `ref_tick`, whatever bits 0 and 1 hold.
- R2: Without bypass, a loop whose control word has bit 0 (reset) or bit 1 (power-down) set gives no ticks, so both outputs stay low while it is selected.
- R3: Bits 5:4 of `clk_ctrl` choose the source: codes 0 and 1 choose the IO loop, code 2 the ARM loop and code 3 the DDR loop.
- R4: Bits 13:8 of `clk_ctrl` hold the divisor D (1 to 63, with 0 treated as 1). An output pulse marks every D-th selected-source tick.
- R5: Bit 0 of `clk_ctrl` enables `ref_out0` and bit 1 enables `ref_out1`. A cleared enable holds its output low while the shared tick count keeps running.
- R6: While `rst` is high, both outputs are low and the tick count is cleared. After release, counting starts from zero.
- R7: Any change of the source or divisor field restarts the count. A source tick in the cycle of the change counts as the first tick under the new setting.
- R8: An output pulse is high exactly in the clock cycle after the source tick it marks, and never without such a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Raw reference tick, used by bypassed loops |
| io_vco_tick | input | 1 | Tick stream of the running IO loop |
| arm_vco_tick | input | 1 | Tick stream of the running ARM loop |
| ddr_vco_tick | input | 1 | Tick stream of the running DDR loop |
| io_pll_ctrl | input | 32 | IO loop control word |
| arm_pll_ctrl | input | 32 | ARM loop control word |
| ddr_pll_ctrl | input | 32 | DDR loop control word |
| clk_ctrl | input | 32 | Source select, divisor and enables |
| ref_out0 | output | 1 | Divided tick strobe, output 0 |
| ref_out1 | output | 1 | Divided tick strobe, output 1 |

## Verification
Every output strobe is due exactly one clock after the source tick and control words that produce it, since there is a single register between them. The bench drives ticks and control words just after a falling edge. At the next falling edge it compares both outputs with the value its arithmetic model predicted from the previous cycle's inputs, so each comparison lands one register stage after its stimulus. Changes of source or divisor take effect in the cycle they are applied, so the model resets its own tick count in that same cycle. Reset asserted in the middle of a run is checked in the same cycle-exact way.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

    localparam int CTRL_W    = 32;
    localparam int NUM_PLL   = 3;
    localparam int PLL_IDX_W = $clog2(NUM_PLL);
    localparam int NUM_OUT   = 2;
    localparam int SEL_W     = 2;
    localparam int DIV_W     = 6;

    localparam int PLL_RST_BIT = 0;
    localparam int PLL_PDN_BIT = 1;
    localparam int PLL_BYP_BIT = 4;
    localparam int EN_LSB      = 0;
    localparam int SEL_LSB     = 4;
    localparam int DIV_LSB     = 8;

    localparam logic [PLL_IDX_W-1:0] IDX_IO  = PLL_IDX_W'(0);
    localparam logic [PLL_IDX_W-1:0] IDX_ARM = PLL_IDX_W'(1);
    localparam logic [PLL_IDX_W-1:0] IDX_DDR = PLL_IDX_W'(2);

    typedef enum logic [1:0] {
        PLL_RUN    = 2'd0,
        PLL_BYPASS = 2'd1,
        PLL_HALT   = 2'd2
    } pll_mode_e;

    typedef struct packed {
        logic [NUM_OUT-1:0] en;
        logic [SEL_W-1:0]   sel;
        logic [DIV_W-1:0]   div;
    } clk_cfg_t;

    // Bypass outranks the stop bits.
    function automatic pll_mode_e pll_mode(input logic [CTRL_W-1:0] w);
        if (w[PLL_BYP_BIT])
            return PLL_BYPASS;
        else if (w[PLL_RST_BIT] || w[PLL_PDN_BIT])
            return PLL_HALT;
        else
            return PLL_RUN;
    endfunction

    function automatic clk_cfg_t clk_cfg(input logic [CTRL_W-1:0] w);
        clk_cfg_t c;
        c.en  = w[EN_LSB  +: NUM_OUT];
        c.sel = w[SEL_LSB +: SEL_W];
        c.div = w[DIV_LSB +: DIV_W];
        return c;
    endfunction

    // Two selector codes land on the IO loop.
    function automatic logic [PLL_IDX_W-1:0] src_index(input logic [SEL_W-1:0] sel);
        case (sel)
            2'd2:    return IDX_ARM;
            2'd3:    return IDX_DDR;
            default: return IDX_IO;
        endcase
    endfunction

    function automatic logic [DIV_W-1:0] div_effective(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction

endpackage

// File: rtl/refclk_pll_stage.sv
module refclk_pll_stage
    import refclk_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              ref_tick,
    input  logic              vco_tick,
    output logic              pll_tick
);
    pll_mode_e mode;

    always_comb begin
        mode = pll_mode(ctrl);
        case (mode)
            PLL_BYPASS: pll_tick = ref_tick;
            PLL_RUN:    pll_tick = vco_tick;
            default:    pll_tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/refclk_src_mux.sv
module refclk_src_mux
    import refclk_pkg::*;
(
    input  logic [NUM_PLL-1:0] pll_ticks,
    input  logic [SEL_W-1:0]   sel,
    output logic               src_tick
);
    logic [PLL_IDX_W-1:0] idx;

    always_comb begin
        idx      = src_index(sel);
        src_tick = 1'b0;
        for (int k = 0; k < NUM_PLL; k++) begin
            if (idx == PLL_IDX_W'(k))
                src_tick = pll_ticks[k];
        end
    end
endmodule

// File: rtl/refclk_tick_div.sv
module refclk_tick_div
    import refclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               src_tick,
    input  logic [SEL_W-1:0]   sel,
    input  logic [DIV_W-1:0]   div_raw,
    input  logic [NUM_OUT-1:0] en,
    output logic [NUM_OUT-1:0] out_tick
);
    localparam int KEY_W = SEL_W + DIV_W;

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] cnt_base;
    logic [DIV_W-1:0] div_eff;
    logic [KEY_W-1:0] key_now;
    logic [KEY_W-1:0] key_q;
    logic             changed;
    logic             hit;

    always_comb begin
        key_now  = {sel, div_raw};
        changed  = (key_now != key_q);
        div_eff  = div_effective(div_raw);
        cnt_base = changed ? '0 : cnt;
        hit      = src_tick && (cnt_base == div_eff - DIV_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            key_q <= key_now;
        end else begin
            key_q <= key_now;
            if (src_tick)
                cnt <= hit ? '0 : cnt_base + DIV_W'(1);
            else
                cnt <= cnt_base;
        end
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst)
                out_tick[i] <= 1'b0;
            else
                out_tick[i] <= hit && en[i];
        end
    end

    AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
        !changed |-> (cnt < div_eff)); // R4

    AST_STROBE_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
        (|out_tick) |-> $past(src_tick)); // R8

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> (out_tick == '0)); // R6

endmodule

// File: rtl/refclk_divider.sv
module refclk_divider
    import refclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              io_vco_tick,
    input  logic              arm_vco_tick,
    input  logic              ddr_vco_tick,
    input  logic [CTRL_W-1:0] io_pll_ctrl,
    input  logic [CTRL_W-1:0] arm_pll_ctrl,
    input  logic [CTRL_W-1:0] ddr_pll_ctrl,
    input  logic [CTRL_W-1:0] clk_ctrl,
    output logic              ref_out0,
    output logic              ref_out1
);
    logic [CTRL_W-1:0]  pll_ctrl_arr [NUM_PLL];
    logic [NUM_PLL-1:0] vco_ticks;
    logic [NUM_PLL-1:0] pll_ticks;
    logic               src_tick;
    clk_cfg_t           cfg;
    logic [NUM_OUT-1:0] outs;

    assign pll_ctrl_arr[IDX_IO]  = io_pll_ctrl;
    assign pll_ctrl_arr[IDX_ARM] = arm_pll_ctrl;
    assign pll_ctrl_arr[IDX_DDR] = ddr_pll_ctrl;
    assign vco_ticks = {ddr_vco_tick, arm_vco_tick, io_vco_tick};
    assign cfg       = clk_cfg(clk_ctrl);

    for (genvar k = 0; k < NUM_PLL; k++) begin : g_pll
        refclk_pll_stage u_stage (
            .ctrl     (pll_ctrl_arr[k]),
            .ref_tick (ref_tick),
            .vco_tick (vco_ticks[k]),
            .pll_tick (pll_ticks[k])
        );
    end

    refclk_src_mux u_mux (
        .pll_ticks (pll_ticks),
        .sel       (cfg.sel),
        .src_tick  (src_tick)
    );

    refclk_tick_div u_div (
        .clk      (clk),
        .rst      (rst),
        .src_tick (src_tick),
        .sel      (cfg.sel),
        .div_raw  (cfg.div),
        .en       (cfg.en),
        .out_tick (outs)
    );

    assign ref_out0 = outs[0];
    assign ref_out1 = outs[1];

    pll_mode_e sel_mode;
    assign sel_mode = pll_mode(pll_ctrl_arr[src_index(cfg.sel)]);

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (sel_mode == PLL_HALT) |=> !(ref_out0 || ref_out1)); // R2

    AST_BYPASS_FOLLOWS_REF: assert property (@(posedge clk) disable iff (rst)
        (sel_mode == PLL_BYPASS && !ref_tick) |=> !(ref_out0 || ref_out1)); // R1

    AST_EN0_GATES: assert property (@(posedge clk) disable iff (rst)
        !clk_ctrl[EN_LSB] |=> !ref_out0); // R5

    AST_EN1_GATES: assert property (@(posedge clk) disable iff (rst)
        !clk_ctrl[EN_LSB + 1] |=> !ref_out1); // R5

endmodule

// File: tb/tb_refclk_divider.sv
`timescale 1ns/1ps
module tb_refclk_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0, io_vco_tick = 1'b0, arm_vco_tick = 1'b0, ddr_vco_tick = 1'b0;
    logic [31:0] io_pll_ctrl = 32'h0001A008, arm_pll_ctrl = 32'h0001A008, ddr_pll_ctrl = 32'h0001A008;
    logic [31:0] clk_ctrl = 32'h00003F03;
    logic        ref_out0, ref_out1;

    always #5 clk = ~clk;

    refclk_divider dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick),
        .io_vco_tick(io_vco_tick), .arm_vco_tick(arm_vco_tick), .ddr_vco_tick(ddr_vco_tick),
        .io_pll_ctrl(io_pll_ctrl), .arm_pll_ctrl(arm_pll_ctrl), .ddr_pll_ctrl(ddr_pll_ctrl),
        .clk_ctrl(clk_ctrl), .ref_out0(ref_out0), .ref_out1(ref_out1)
    );

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;

    // Desired settings, applied by step() just after a falling edge.
    logic        w_rst = 1'b1, w_dense = 1'b0;
    logic [31:0] w_io = 32'h0001A008, w_arm = 32'h0001A008, w_ddr = 32'h0001A008;
    logic [31:0] w_clk = 32'h00003F03;

    // Model state
    logic [1:0]  exp_out = 2'b00;
    logic [7:0]  prev_key = 8'h00;
    int          mcnt = 0;
    int          pulses = 0;

    function automatic logic loop_src(input logic [31:0] c, input logic r, input logic v);
        if (c[4]) return r;          // R1
        if (c[0] || c[1]) return 1'b0; // R2
        return v;
    endfunction

    task automatic step(input string tag);
        logic s;
        logic [7:0] key;
        int d, base;
        @(negedge clk);
        checks++;
        if ({ref_out1, ref_out0} !== exp_out) begin
            failures++;
            $display("FAIL %s: out=%b expected=%b cycle=%0d", tag, {ref_out1, ref_out0}, exp_out, cyc);
        end
        if ({ref_out1, ref_out0} === 2'b11 || {ref_out1, ref_out0} === 2'b01 || {ref_out1, ref_out0} === 2'b10)
            pulses++;
        cyc++;
        rst = w_rst;
        io_pll_ctrl = w_io; arm_pll_ctrl = w_arm; ddr_pll_ctrl = w_ddr; clk_ctrl = w_clk;
        ref_tick     = w_dense || (cyc % 7 == 0);
        io_vco_tick  = w_dense || (cyc % 2 == 0);
        arm_vco_tick = w_dense || (cyc % 3 == 0);
        ddr_vco_tick = w_dense || (cyc % 5 == 0);
        // R3 source map
        case (clk_ctrl[5:4])
            2'd2:    s = loop_src(arm_pll_ctrl, ref_tick, arm_vco_tick);
            2'd3:    s = loop_src(ddr_pll_ctrl, ref_tick, ddr_vco_tick);
            default: s = loop_src(io_pll_ctrl, ref_tick, io_vco_tick);
        endcase
        d = (clk_ctrl[13:8] == 0) ? 1 : int'(clk_ctrl[13:8]); // R4
        key = {clk_ctrl[5:4], clk_ctrl[13:8]};
        base = (rst || key != prev_key) ? 0 : mcnt;            // R7
        prev_key = key;
        if (rst) begin
            mcnt = 0; exp_out = 2'b00;                          // R6
        end else if (s) begin
            if (base + 1 == d) begin
                mcnt = 0; exp_out = clk_ctrl[1:0];              // R5 R8
            end else begin
                mcnt = base + 1; exp_out = 2'b00;
            end
        end else begin
            mcnt = base; exp_out = 2'b00;
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        int divs[6] = '{0, 1, 2, 3, 5, 63};
        int per;
        // R6 reset state
        run(3, "R6 reset state");
        w_rst = 1'b0;
        run(200, "R4 default /63 io");

        // R3 R4 sweep over source codes and divisors
        for (int s = 0; s < 4; s++) begin
            for (int j = 0; j < 6; j++) begin
                per = (s == 2) ? 3 : (s == 3) ? 5 : 2;
                w_clk = 32'h3 | (32'(s) << 4) | (32'(divs[j]) << 8);
                pulses = 0;
                run(((divs[j] == 0) ? 1 : divs[j]) * per * 2 + 12, "R3 R4 sweep");
                checks++;
                if (pulses == 0) begin
                    failures++;
                    $display("FAIL R4 sweep: pulses=%0d expected=nonzero sel=%0d div=%0d", pulses, s, divs[j]);
                end
            end
        end

        // R5 enables, dense ticks
        w_dense = 1'b1;
        for (int e = 0; e < 4; e++) begin
            w_clk = 32'(e) | (32'd3 << 8);
            run(20, "R5 enables");
        end

        // R1 R2 loop modes on each loop
        w_dense = 1'b0;
        for (int k = 0; k < 3; k++) begin
            for (int m = 0; m < 8; m++) begin
                logic [31:0] c;
                c = 32'h0001A008 & ~32'h13;
                c = c | (m[0] ? 32'h1 : 0) | (m[1] ? 32'h2 : 0) | (m[2] ? 32'h10 : 0);
                w_io = 32'h0001A008; w_arm = 32'h0001A008; w_ddr = 32'h0001A008;
                if (k == 0) w_io = c; else if (k == 1) w_arm = c; else w_ddr = c;
                w_clk = 32'h3 | (32'(k == 0 ? 1 : k + 1) << 4) | (32'd2 << 8);
                run(50, "R1 R2 loop mode");
            end
        end
        w_io = 32'h0001A008; w_arm = 32'h0001A008; w_ddr = 32'h0001A008;

        // R7 restart on divisor change mid-count
        w_dense = 1'b1;
        w_clk = 32'h3 | (32'd5 << 8);
        run(8, "R7 setup");
        w_clk = 32'h3 | (32'd4 << 8);
        run(12, "R7 divisor change");
        w_clk = 32'h3 | (32'd2 << 4) | (32'd4 << 8);
        run(12, "R7 source change");

        // R8 divide by one, pulse per tick
        w_clk = 32'h3;
        run(10, "R8 latency");

        // R6 reset mid-run
        w_clk = 32'h3 | (32'd3 << 8);
        run(2, "R6 pre");
        w_rst = 1'b1;
        run(4, "R6 mid-run reset");
        w_rst = 1'b0;
        run(12, "R6 after release");

        done = 1;
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run hung, expected completion");
            finish_up();
        end
    end

endmodule